// File: doc/BRIEF.md
# Single-Address DMA Channel

This block is one DMA channel that moves a run of 32-bit words between system memory and a single fixed peripheral data port. Only the memory side is addressed: the channel walks a current-address register upward from a programmed base while a remaining-count register walks down to zero. The peripheral side has no address. It is a valid/ready word stream, with one stream leaving the block (memory to peripheral) and one entering it (peripheral to memory). The memory side is a request/ready word port that completes an access in the cycle in which `mem_ready` is high.

Software programs the channel through a 32-bit register port. It writes a configuration word, a base address and a byte length, then writes a nonzero value to the run register. Progress stays visible while the channel works, because the current address and the remaining count can be read at any time. The length minus the remaining count gives the bytes already moved. When a transfer ends, the channel sets an end bit in an interrupt status register. The interrupt line is the OR of status bits that are also enabled, and it stays high until software writes a one to the matching bit of a separate clear register.

The control sequencer has six states. IDLE waits for a start. FETCH reads a memory word, SEND offers it on the outgoing stream, CAPTURE accepts a word from the incoming stream, STORE writes it to memory, and PAUSE inserts the configured idle cycles after a memory access. The transitions are as follows.
- start in transmit mode: IDLE to FETCH. Start in receive mode: IDLE to CAPTURE.
- memory ready: FETCH to PAUSE when the wait field is nonzero, otherwise FETCH to SEND.
- handshake in SEND: back to FETCH, or to IDLE on the final word.
- handshake in CAPTURE: on to STORE.
- memory ready in STORE: to PAUSE when the wait field is nonzero. Otherwise to CAPTURE, or to IDLE on the final word.
- end of the wait in PAUSE: to SEND in transmit mode, and to CAPTURE or IDLE in receive mode.
- halt: from any busy state to IDLE.

Top module: `sadma_channel`

## Requirements
- R1: After reset, every readable register reads 0, `irq` is low and no memory request, stream valid or stream ready is driven.
- R2: The registers read back as follows. The configuration word (offset 0x00) keeps only bit 12 (transmit mode), bit 8 (receive end mode) and bits 5:4 (wait count), so writing all ones reads 0x00001130. Base (0x10) keeps 32 bits, length (0x18) keeps 26 bits, so writing all ones reads 0x03FFFFFF. Interrupt enable (0x40) keeps 2 bits.
- R3: Writing a nonzero value to the run register (0x30) from idle copies base into current address (0x20) and length into remaining count (0x28). The run register reads 1 while the channel is busy and 0 when it is idle.
- R4: With configuration bit 12 set, the channel reads memory words at consecutive addresses from base upward and presents them in order on the outgoing stream. Each word is held stable until it is accepted.
- R5: With configuration bit 12 clear, the channel accepts incoming stream words and writes them to consecutive memory addresses from base upward. It writes nothing outside the programmed range.
- R6: Each word moved adds 4 to the current address and subtracts 4 from the remaining count. On normal completion the current address equals base plus length, the remaining count is 0 and the run register reads 0.
- R7: After every memory access the channel waits for as many idle cycles as the wait field holds, driving nothing. With memory and stream always ready, a transfer of N words keeps the channel busy for exactly N·(2+W) cycles.
- R8: The end of a transfer sets bit 0 of the status register (0x44). `irq` is high exactly when a status bit and its enable bit are both 1.
- R9: Writing 1 to a bit of the clear register (0x48) clears that status bit. Writing 0 to a bit leaves that bit unchanged.
- R10: Writing 0 to the run register while busy stops the channel at once, without setting status. The current address and remaining count keep their partial values, and no further memory or stream activity occurs.
- R11: In receive mode with configuration bit 8 set, an incoming word flagged `per_rx_last` is stored and then ends the transfer, which sets status. With bit 8 clear, the flag is ignored.
- R12: Starting with a length of 0 completes at once. The run register reads 0, status bit 0 sets and no memory access occurs.
- R13: While the channel is busy, another start write is ignored. Writes to base, length or configuration do not change the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt: OR of enabled status bits |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address, the current address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory completes the access in this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| per_tx_valid | output | 1 | Outgoing stream word valid |
| per_tx_data | output | 32 | Outgoing stream word |
| per_tx_ready | input | 1 | Peripheral accepts the outgoing word |
| per_rx_valid | input | 1 | Incoming stream word valid |
| per_rx_data | input | 32 | Incoming stream word |
| per_rx_last | input | 1 | Incoming word is the last one, used in end mode |
| per_rx_ready | output | 1 | Channel accepts the incoming word |

## Verification
The hardest case to reach is a transfer parked partway through. That case covers a halt, a second start and register rewrites arriving while the channel is busy. The bench reaches it by letting the incoming stream supply only a fixed number of words, so the sequencer waits in CAPTURE with a known partial count. It then issues the halt or the rewrites, reads the live registers and checks that the stream ports stay quiet. A full sweep of both directions, all four wait values and several lengths pins the cycle count of each transfer arithmetically.

// File: rtl/sadma_pkg.sv
package sadma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND,
        ST_CAPTURE,
        ST_STORE,
        ST_PAUSE
    } dma_state_t;

    // Register byte offsets decoded by software
    localparam logic [7:0] OFS_CONF = 8'h00;
    localparam logic [7:0] OFS_BASE = 8'h10;
    localparam logic [7:0] OFS_LEN  = 8'h18;
    localparam logic [7:0] OFS_CUR  = 8'h20;
    localparam logic [7:0] OFS_LEFT = 8'h28;
    localparam logic [7:0] OFS_RUN  = 8'h30;
    localparam logic [7:0] OFS_IEN  = 8'h40;
    localparam logic [7:0] OFS_IST  = 8'h44;
    localparam logic [7:0] OFS_ICLR = 8'h48;

    // Field positions inside the configuration word
    localparam int CONF_TX_BIT   = 12;
    localparam int CONF_END_BIT  = 8;
    localparam int CONF_WAIT_LSB = 4;

    typedef struct packed {
        logic       tx_mode;
        logic       end_mode;
        logic [1:0] wait_cycles;
    } chan_cfg_t;

endpackage

// File: rtl/sadma_regs.sv
module sadma_regs
    import sadma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 26,
    parameter int NUM_IRQ  = 2,
    parameter int IRQ_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output chan_cfg_t         cfg,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  len,
    output logic              start_pulse,
    output logic              halt_pulse,
    input  logic              eng_busy,
    input  logic [ADDR_W-1:0] eng_cur,
    input  logic [CNT_W-1:0]  eng_left,
    input  logic              eng_done,
    output logic              irq
);

    logic [NUM_IRQ-1:0] ien_q;
    logic [NUM_IRQ-1:0] ist_q;
    logic [NUM_IRQ-1:0] clr_mask;
    logic               wr_run;

    assign wr_run      = wr_en && (addr == OFS_RUN);
    assign start_pulse = wr_run && (wdata != 32'd0) && !eng_busy;
    assign halt_pulse  = wr_run && (wdata == 32'd0) && eng_busy;
    assign clr_mask    = (wr_en && addr == OFS_ICLR) ? wdata[NUM_IRQ-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg   <= '0;
            base  <= '0;
            len   <= '0;
            ien_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFS_CONF: begin
                    cfg.tx_mode     <= wdata[CONF_TX_BIT];
                    cfg.end_mode    <= wdata[CONF_END_BIT];
                    cfg.wait_cycles <= wdata[CONF_WAIT_LSB +: 2];
                end
                OFS_BASE: base  <= wdata[ADDR_W-1:0];
                OFS_LEN:  len   <= wdata[CNT_W-1:0];
                OFS_IEN:  ien_q <= wdata[NUM_IRQ-1:0];
                default: ;
            endcase
        end
    end

    // One status flop per interrupt source; only this channel's bit has a setter
    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_status
        logic set_bit;
        if (gi == IRQ_BIT) begin : g_own
            assign set_bit = eng_done;
        end else begin : g_other
            assign set_bit = 1'b0;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          ist_q[gi] <= 1'b0;
            else if (set_bit)    ist_q[gi] <= 1'b1;
            else if (clr_mask[gi]) ist_q[gi] <= 1'b0;
        end
    end

    assign irq = |(ist_q & ien_q);

    always_comb begin
        rdata = 32'd0;
        unique case (addr)
            OFS_CONF: begin
                rdata[CONF_TX_BIT]          = cfg.tx_mode;
                rdata[CONF_END_BIT]         = cfg.end_mode;
                rdata[CONF_WAIT_LSB +: 2]   = cfg.wait_cycles;
            end
            OFS_BASE: rdata = 32'(base);
            OFS_LEN:  rdata = 32'(len);
            OFS_CUR:  rdata = 32'(eng_cur);
            OFS_LEFT: rdata = 32'(eng_left);
            OFS_RUN:  rdata = {31'd0, eng_busy};
            OFS_IEN:  rdata = 32'(ien_q);
            OFS_IST:  rdata = 32'(ist_q);
            default:  rdata = 32'd0;
        endcase
    end

    assert_done_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> ist_q[IRQ_BIT]);

    assert_clear_zero_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_ICLR && wdata[NUM_IRQ-1:0] == '0 && !eng_done) |=> $stable(ist_q));

endmodule

// File: rtl/sadma_engine.sv
module sadma_engine
    import sadma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 26,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              halt,
    input  chan_cfg_t         cfg,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  len,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  left,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    output logic              rx_ready
);

    localparam int                BEAT_BYTES = DATA_W / 8;
    localparam logic [CNT_W-1:0]  BEAT_CNT   = CNT_W'(BEAT_BYTES);
    localparam logic [ADDR_W-1:0] BEAT_ADR   = ADDR_W'(BEAT_BYTES);

    dma_state_t        state_q, state_d;
    chan_cfg_t         cfg_q;
    logic [ADDR_W-1:0] cur_q;
    logic [CNT_W-1:0]  left_q;
    logic [DATA_W-1:0] data_q;
    logic              last_q;
    logic              fin_q;
    logic [1:0]        wcnt_q;
    logic              beat;
    logic              fin;
    logic              end_now;
    logic              zero_start;

    assign end_now    = (left_q == BEAT_CNT) || (cfg_q.end_mode && last_q);
    assign zero_start = (state_q == ST_IDLE) && start && (len == '0);

    // Next-state and beat decisions
    always_comb begin
        state_d = state_q;
        beat    = 1'b0;
        fin     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && len != '0)
                    state_d = cfg.tx_mode ? ST_FETCH : ST_CAPTURE;
            end
            ST_FETCH: begin
                if (mem_ready)
                    state_d = (cfg_q.wait_cycles != 2'd0) ? ST_PAUSE : ST_SEND;
            end
            ST_SEND: begin
                if (tx_ready) begin
                    beat = 1'b1;
                    if (left_q == BEAT_CNT) begin
                        fin     = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_CAPTURE: begin
                if (rx_valid) state_d = ST_STORE;
            end
            ST_STORE: begin
                if (mem_ready) begin
                    beat = 1'b1;
                    if (cfg_q.wait_cycles != 2'd0) begin
                        state_d = ST_PAUSE;
                    end else if (end_now) begin
                        fin     = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_CAPTURE;
                    end
                end
            end
            ST_PAUSE: begin
                if (wcnt_q == 2'd1) begin
                    if (cfg_q.tx_mode) begin
                        state_d = ST_SEND;
                    end else if (fin_q) begin
                        fin     = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_CAPTURE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (halt) state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            cur_q  <= '0;
            left_q <= '0;
            data_q <= '0;
            last_q <= 1'b0;
            fin_q  <= 1'b0;
            wcnt_q <= 2'd0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                cur_q  <= base;
                left_q <= len;
                cfg_q  <= cfg;
                last_q <= 1'b0;
            end else if (beat) begin
                cur_q  <= cur_q + BEAT_ADR;
                left_q <= left_q - BEAT_CNT;
            end
            if (state_q == ST_FETCH && mem_ready) data_q <= mem_rdata;
            if (state_q == ST_CAPTURE && rx_valid) begin
                data_q <= rx_data;
                last_q <= rx_last;
            end
            if (state_d == ST_PAUSE && state_q != ST_PAUSE) begin
                wcnt_q <= cfg_q.wait_cycles;
                fin_q  <= end_now;
            end else if (state_q == ST_PAUSE) begin
                wcnt_q <= wcnt_q - 2'd1;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        tx_valid = 1'b0;
        rx_ready = 1'b0;
        unique case (state_q)
            ST_FETCH:   mem_req  = 1'b1;
            ST_STORE:   begin mem_req = 1'b1; mem_we = 1'b1; end
            ST_SEND:    tx_valid = 1'b1;
            ST_CAPTURE: rx_ready = 1'b1;
            default: ;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = (fin && !halt) || zero_start;
    assign cur_addr  = cur_q;
    assign left      = left_q;
    assign mem_addr  = cur_q;
    assign mem_wdata = data_q;
    assign tx_data   = data_q;

    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !halt) |=> (tx_valid && $stable(tx_data)));

    assert_beat_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && cur_addr != $past(cur_addr))
            |-> (cur_addr == $past(cur_addr) + BEAT_ADR && left == $past(left) - BEAT_CNT));

    assert_pause_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && cfg_q.wait_cycles != 2'd0 && !halt)
            |=> (!mem_req && !tx_valid && !rx_ready));

    assert_halt_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!busy && !mem_req && !tx_valid && !rx_ready));

    assert_zero_len_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && len == '0) |=> !busy);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/sadma_channel.sv
module sadma_channel
    import sadma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 26,
    parameter int NUM_IRQ = 2,
    parameter int IRQ_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              per_tx_valid,
    output logic [31:0]       per_tx_data,
    input  logic              per_tx_ready,
    input  logic              per_rx_valid,
    input  logic [31:0]       per_rx_data,
    input  logic              per_rx_last,
    output logic              per_rx_ready
);

    chan_cfg_t         cfg;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  len;
    logic              start_pulse;
    logic              halt_pulse;
    logic              eng_busy;
    logic              eng_done;
    logic [ADDR_W-1:0] eng_cur;
    logic [CNT_W-1:0]  eng_left;

    sadma_regs #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .NUM_IRQ (NUM_IRQ),
        .IRQ_BIT (IRQ_BIT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .cfg         (cfg),
        .base        (base),
        .len         (len),
        .start_pulse (start_pulse),
        .halt_pulse  (halt_pulse),
        .eng_busy    (eng_busy),
        .eng_cur     (eng_cur),
        .eng_left    (eng_left),
        .eng_done    (eng_done),
        .irq         (irq)
    );

    sadma_engine #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DATA_W (32)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_pulse),
        .halt      (halt_pulse),
        .cfg       (cfg),
        .base      (base),
        .len       (len),
        .busy      (eng_busy),
        .done      (eng_done),
        .cur_addr  (eng_cur),
        .left      (eng_left),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .tx_valid  (per_tx_valid),
        .tx_data   (per_tx_data),
        .tx_ready  (per_tx_ready),
        .rx_valid  (per_rx_valid),
        .rx_data   (per_rx_data),
        .rx_last   (per_rx_last),
        .rx_ready  (per_rx_ready)
    );

endmodule

// File: tb/sadma_channel_tb.sv
module sadma_channel_tb;

    localparam logic [7:0] A_CONF = 8'h00, A_BASE = 8'h10, A_LEN = 8'h18, A_CUR = 8'h20;
    localparam logic [7:0] A_LEFT = 8'h28, A_RUN = 8'h30, A_IEN = 8'h40, A_IST = 8'h44, A_ICLR = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        per_tx_valid, per_tx_ready;
    logic [31:0] per_tx_data;
    logic        per_rx_valid, per_rx_last, per_rx_ready;
    logic [31:0] per_rx_data;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [31:0] bmem [0:63];
    logic [31:0] tx_log [0:255];
    int tx_n = 0;
    int rx_idx = 0;
    int rx_limit = 1000000;
    int rx_last_at = -1;
    int mem_hs = 0;
    bit tx_rdy = 1'b1;

    always #5 clk = ~clk;

    function automatic logic [31:0] mem_pat(int i);
        return 32'h1000_0000 + 32'(i) * 32'd17;
    endfunction

    function automatic logic [31:0] rx_pat(int i);
        return 32'hC0DE_0000 + 32'(i) * 32'd7;
    endfunction

    assign mem_ready    = mem_req;
    assign mem_rdata    = bmem[mem_addr[7:2]];
    assign per_tx_ready = tx_rdy;
    assign per_rx_valid = (rx_idx < rx_limit);
    assign per_rx_data  = rx_pat(rx_idx);
    assign per_rx_last  = (rx_idx == rx_last_at);

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            mem_hs <= mem_hs + 1;
            if (mem_we) bmem[mem_addr[7:2]] <= mem_wdata;
        end
        if (per_tx_valid && per_tx_ready) begin
            tx_log[tx_n[7:0]] <= per_tx_data;
            tx_n <= tx_n + 1;
        end
        if (per_rx_valid && per_rx_ready) rx_idx <= rx_idx + 1;
    end

    sadma_channel u_dut (
        .clk (clk), .rst_n (rst_n),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .irq (irq),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_ready (mem_ready), .mem_rdata (mem_rdata),
        .per_tx_valid (per_tx_valid), .per_tx_data (per_tx_data), .per_tx_ready (per_tx_ready),
        .per_rx_valid (per_rx_valid), .per_rx_data (per_rx_data), .per_rx_last (per_rx_last),
        .per_rx_ready (per_rx_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_RUN;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Counts busy cycles from the start edge until the run register reads 0
    task automatic wait_idle(output int cyc);
        cyc = 0;
        reg_addr = A_RUN;
        #1;
        while (reg_rdata != 32'd0 && cyc < 2000) begin
            cyc++;
            @(negedge clk);
            reg_addr = A_RUN;
            #1;
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) bmem[i] = mem_pat(i);
        for (int i = 0; i < 256; i++) tx_log[i] = 32'd0;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CONF, v); chk("R1 conf", v, 0);
        rd(A_BASE, v); chk("R1 base", v, 0);
        rd(A_LEN,  v); chk("R1 len", v, 0);
        rd(A_CUR,  v); chk("R1 cur", v, 0);
        rd(A_LEFT, v); chk("R1 left", v, 0);
        rd(A_RUN,  v); chk("R1 run", v, 0);
        rd(A_IEN,  v); chk("R1 ien", v, 0);
        rd(A_IST,  v); chk("R1 ist", v, 0);
        chk("R1 irq/req/valid/ready", {28'd0, irq, mem_req, per_tx_valid, per_rx_ready}, 0);

        // R2 field masking
        wr(A_CONF, 32'hFFFF_FFFF); rd(A_CONF, v); chk("R2 conf", v, 32'h0000_1130);
        wr(A_BASE, 32'hFFFF_FFFF); rd(A_BASE, v); chk("R2 base", v, 32'hFFFF_FFFF);
        wr(A_LEN,  32'hFFFF_FFFF); rd(A_LEN,  v); chk("R2 len", v, 32'h03FF_FFFF);
        wr(A_IEN,  32'hFFFF_FFFF); rd(A_IEN,  v); chk("R2 ien", v, 32'h0000_0003);
        wr(A_IEN, 32'd1);

        // Sweep: direction x wait x length
        for (int dir = 1; dir >= 0; dir--) begin
            for (int w = 0; w < 4; w++) begin
                for (int li = 0; li < 4; li++) begin
                    int n;
                    int s_tx;
                    int s_rx;
                    int bidx;
                    logic [31:0] b;
                    logic [31:0] guard;
                    n = (li == 3) ? 7 : li + 1;
                    bidx = w * 4 + li;
                    b = 32'h8000_0000 + 32'(bidx) * 4;
                    guard = bmem[bidx + n];
                    s_tx = tx_n; s_rx = rx_idx;
                    wr(A_CONF, (32'(dir) << 12) | (32'(w) << 4));
                    wr(A_BASE, b);
                    wr(A_LEN, 32'(n * 4));
                    wr(A_RUN, 32'd1);
                    wait_idle(cyc);
                    chk("R7 busy cycles", 32'(cyc), 32'(n * (2 + w)));
                    rd(A_CUR, v);  chk("R6 final cur", v, b + 32'(n * 4));
                    rd(A_LEFT, v); chk("R6 final left", v, 0);
                    rd(A_IST, v);  chk("R8 status set", v, 1);
                    chk("R8 irq high", {31'd0, irq}, 1);
                    if (dir == 1) begin
                        chk("R4 word count", 32'(tx_n - s_tx), 32'(n));
                        for (int k = 0; k < n; k++)
                            chk("R4 tx data", tx_log[(s_tx + k) % 256], bmem[bidx + k]);
                    end else begin
                        chk("R5 word count", 32'(rx_idx - s_rx), 32'(n));
                        for (int k = 0; k < n; k++)
                            chk("R5 stored data", bmem[bidx + k], rx_pat(s_rx + k));
                        chk("R5 guard untouched", bmem[bidx + n], guard);
                    end
                    wr(A_ICLR, 32'd1);
                    rd(A_IST, v); chk("R9 cleared", v, 0);
                    chk("R8 irq low", {31'd0, irq}, 0);
                end
            end
        end

        // R9 clear semantics and R8 masking
        wr(A_IEN, 32'd0);
        wr(A_LEN, 32'd0);
        wr(A_RUN, 32'd1);
        rd(A_IST, v); chk("R8 status with mask off", v, 1);
        chk("R8 irq masked", {31'd0, irq}, 0);
        wr(A_ICLR, 32'd0); rd(A_IST, v); chk("R9 write zero keeps", v, 1);
        wr(A_ICLR, 32'd2); rd(A_IST, v); chk("R9 other bit keeps", v, 1);
        wr(A_IEN, 32'd1);  chk("R8 irq after enable", {31'd0, irq}, 1);
        wr(A_ICLR, 32'd1); rd(A_IST, v); chk("R9 write one clears", v, 0);

        // R10 halt while parked, R13 writes while busy
        begin
            int s;
            logic [31:0] b;
            b = 32'h8000_0080;
            s = rx_idx;
            rx_limit = s + 2;
            wr(A_CONF, 32'd0); wr(A_BASE, b); wr(A_LEN, 32'd16); wr(A_RUN, 32'd1);
            repeat (20) @(negedge clk);
            rd(A_RUN, v);  chk("R3 run reads busy", v, 1);
            rd(A_LEFT, v); chk("R3 partial left", v, 8);
            rd(A_CUR, v);  chk("R3 partial cur", v, b + 8);
            wr(A_BASE, 32'h1234_5670); wr(A_LEN, 32'h40); wr(A_CONF, 32'h1030); wr(A_RUN, 32'd5);
            rd(A_CUR, v);  chk("R13 cur unchanged", v, b + 8);
            rd(A_LEFT, v); chk("R13 left unchanged", v, 8);
            wr(A_RUN, 32'd0);
            rd(A_RUN, v);  chk("R10 run after halt", v, 0);
            rd(A_IST, v);  chk("R10 no status", v, 0);
            rd(A_LEFT, v); chk("R10 left kept", v, 8);
            rd(A_CUR, v);  chk("R10 cur kept", v, b + 8);
            rx_limit = 1000000;
            repeat (5) @(negedge clk);
            chk("R10 quiet ports", {29'd0, mem_req, per_tx_valid, per_rx_ready}, 0);
            chk("R10 no more words", 32'(rx_idx), 32'(s + 2));
        end

        // R13 start ignored while busy, run completes with original settings
        begin
            int s;
            logic [31:0] b;
            b = 32'h8000_00A0;
            s = rx_idx;
            rx_limit = s + 1;
            wr(A_CONF, 32'd0); wr(A_BASE, b); wr(A_LEN, 32'd12); wr(A_RUN, 32'd1);
            repeat (6) @(negedge clk);
            wr(A_BASE, 32'h0000_0000); wr(A_LEN, 32'h100); wr(A_CONF, 32'h1000); wr(A_RUN, 32'd1);
            rx_limit = 1000000;
            wait_idle(cyc);
            rd(A_CUR, v);  chk("R13 original end", v, b + 12);
            rd(A_LEFT, v); chk("R13 original left", v, 0);
            chk("R13 data kept", bmem[42], rx_pat(s + 2));
            wr(A_ICLR, 32'd1);
        end

        // R11 end mode with last flag, and flag ignored without it
        begin
            int s;
            logic [31:0] b;
            b = 32'h8000_00C0;
            s = rx_idx;
            rx_last_at = s + 2;
            wr(A_CONF, 32'h100); wr(A_BASE, b); wr(A_LEN, 32'd20); wr(A_RUN, 32'd1);
            wait_idle(cyc);
            rd(A_CUR, v);  chk("R11 early end cur", v, b + 12);
            rd(A_LEFT, v); chk("R11 early end left", v, 8);
            rd(A_IST, v);  chk("R11 status set", v, 1);
            chk("R11 last word stored", bmem[50], rx_pat(s + 2));
            wr(A_ICLR, 32'd1);
            s = rx_idx;
            rx_last_at = s + 1;
            wr(A_CONF, 32'h0); wr(A_BASE, b); wr(A_LEN, 32'd12); wr(A_RUN, 32'd1);
            wait_idle(cyc);
            rd(A_LEFT, v); chk("R11 flag ignored", v, 0);
            chk("R11 words taken", 32'(rx_idx - s), 3);
            rx_last_at = -1;
            wr(A_ICLR, 32'd1);
        end

        // R12 zero length
        begin
            int h;
            h = mem_hs;
            wr(A_LEN, 32'd0); wr(A_RUN, 32'd1);
            rd(A_RUN, v); chk("R12 idle at once", v, 0);
            rd(A_IST, v); chk("R12 status set", v, 1);
            chk("R12 no memory access", 32'(mem_hs), 32'(h));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule